// File: doc/BRIEF.md
# Compare-Match Timer with DMA Request Output

This block is a free-running 16-bit up-counter that advances once per prescaled clock tick. A two-bit select picks the tick period: 4, 8, 16 or 64 clocks. Each tick compares the counter with a programmable limit. When they are equal on a tick, the counter returns to zero instead of incrementing. A sticky match flag is set. A single-clock request pulse is driven out, so that a DMA channel can use each match as a transfer trigger.

Software controls the block through four 16-bit registers on a simple single-cycle port. The port has a 2-bit address, a write strobe, write data and combinational read data. The registers are a run control, a control/status word holding the flag and the tick select, the counter, and the limit. Stopping the timer freezes the counter and zeroes the prescaler, so every start begins with a full tick period.

Top module: `match_timer`

## Requirements
- R1: After reset, all four registers read 0 and `dma_req` is low.
- R2: Bit 0 of the run register (address 0) lets the counter advance when 1; when it is 0, the counter holds its value.
- R3: Bits 1:0 of the control register (address 1) set the tick period: code 0 gives 4 clocks, 1 gives 8, 2 gives 16 and 3 gives 64.
- R4: The first counter tick comes exactly one full tick period after the edge that sets the run bit, whatever the prescaler held before the stop.
- R5: A tick that finds the counter equal to the limit loads the counter with 0 and sets the match flag (control register bit 7). Otherwise a tick adds 1 to the counter.
- R6: `dma_req` goes high for exactly one clock after every matching tick. With limit L and period P, matches occur every P*(L+1) clocks.
- R7: The match flag stays set until a control-register write with bit 7 = 0. A write with bit 7 = 1 leaves the flag unchanged.
- R8: Writing the counter (address 2) loads it directly, and the limit (address 3) reads back as written. A counter loaded at value C reaches its first match after L-C+1 ticks.
- R9: With the limit at 0, every tick is a match, so `dma_req` pulses once per tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that is prescaled |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 run, 1 control, 2 counter, 3 limit |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register, combinational |
| dma_req | output | 1 | One-clock request pulse per compare match |

## Verification
A faulty prescaler or tick select shows up as a request pulse that lands on the wrong clock. This becomes visible at the first match after a start, and that match is never more than P*(L+1) clocks away. A wrong counter or compare path moves every later pulse or removes it. A wrong flag or halt path shows up when the control or counter register is read during a stop. For that reason, the request timing is checked to the exact cycle after each start, and the registers are read back while the timer is stopped.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    ADDR_RUN   = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_LIMIT = 2'd3
  } reg_addr_e;

  localparam int FLAG_BIT = 7;

  // Clocks per counter tick for a given select code.
  function automatic int unsigned tick_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  import cmt_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_w;

  assign last_w = PRE_W'(tick_period(sel) - 1);
  assign tick   = run && (pre_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R4
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

endmodule

// File: rtl/cmt_compare.sv
module cmt_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             flag,
  output logic             req
);

  logic             match_w;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic             flag_q;
  logic             req_q;

  assign match_w = tick && (count_q == limit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '0;
      flag_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (cnt_wr)       count_q <= wdata;
      else if (match_w) count_q <= '0;
      else if (tick)    count_q <= count_q + 1'b1;
      if (lim_wr)       limit_q <= wdata;
      if (match_w)      flag_q  <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      req_q <= match_w;
    end
  end

  assign count = count_q;
  assign limit = limit_q;
  assign flag  = flag_q;
  assign req   = req_q;

  // R5
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_w && !cnt_wr) |=> (count_q == '0 && flag_q));

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             dma_req
);
  import cmt_pkg::*;

  logic             run_q;
  logic [1:0]       sel_q;
  logic             tick;
  logic             wr_run, wr_ctrl, wr_count, wr_limit;
  logic             flag_clr;
  logic [CNT_W-1:0] count, limit;
  logic             flag;

  assign wr_run   = reg_wr && (reg_addr_e'(reg_addr) == ADDR_RUN);
  assign wr_ctrl  = reg_wr && (reg_addr_e'(reg_addr) == ADDR_CTRL);
  assign wr_count = reg_wr && (reg_addr_e'(reg_addr) == ADDR_COUNT);
  assign wr_limit = reg_wr && (reg_addr_e'(reg_addr) == ADDR_LIMIT);
  assign flag_clr = wr_ctrl && !reg_wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= 2'd0;
    end else begin
      if (wr_run)  run_q <= reg_wdata[0];
      if (wr_ctrl) sel_q <= reg_wdata[1:0];
    end
  end

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .sel   (sel_q),
    .tick  (tick)
  );

  cmt_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt_wr   (wr_count),
    .lim_wr   (wr_limit),
    .wdata    (reg_wdata),
    .flag_clr (flag_clr),
    .count    (count),
    .limit    (limit),
    .flag     (flag),
    .req      (dma_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      ADDR_RUN:   reg_rdata[0] = run_q;
      ADDR_CTRL:  begin
        reg_rdata[FLAG_BIT] = flag;
        reg_rdata[1:0]      = sel_q;
      end
      ADDR_COUNT: reg_rdata = count;
      default:    reg_rdata = limit;
    endcase
  end

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_count) |=> $stable(count));

  // R6
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(run_q));

endmodule

// File: tb/match_timer_test.sv
module match_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dma_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_q[$];
  logic prev_req = 1'b0;
  bit finished = 1'b0;

  match_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(input int sel);
    return (sel == 3) ? 64 : (4 << sel);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Returns the index of the clock edge on which the write took effect.
  task automatic wr(input int a, input int d, output int edge_idx);
    @(negedge clk);
    reg_addr = 2'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    edge_idx = cyc;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 2'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: compares each request pulse against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (dma_req) begin
        if (prev_req) check("R6 pulse width", 2, 1);
        if (exp_q.size() == 0) check("R6 unexpected pulse", cyc, -1);
        else check("R6/R3 pulse cycle", cyc, exp_q.pop_front());
      end
      prev_req = dma_req;
    end
  end

  // Starts the timer and pushes the expected pulse cycles.
  task automatic start_and_expect(input int sel, input int lim, input int c0,
                                  input int n, output int w);
    int p;
    p = period_of(sel);
    wr(0, 1, w);
    exp_q.push_back(w + p * (lim - c0 + 1));
    for (int k = 1; k < n; k++) exp_q.push_back(w + p * (lim - c0 + 1) + p * (lim + 1) * k);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, w, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      check("R1 reset register", v, 0);
    end
    check("R1 dma_req low", int'(dma_req), 0);

    // R8 limit readback, R5/R6 periodic matches at /4 limit 3
    wr(3, 3, w);
    rd(3, v);
    check("R8 limit readback", v, 3);
    wr(1, 0, w);
    start_and_expect(0, 3, 0, 3, w);
    wait_until(w + 52);
    wr(0, 0, v2);
    check("R6 all pulses seen", exp_q.size(), 0);
    rd(1, v);
    check("R5 flag set", (v >> 7) & 1, 1);

    // R2 halt holds counter
    rd(2, v);
    repeat (40) @(negedge clk);
    rd(2, v2);
    check("R2 counter holds when stopped", v2, v);

    // R7 flag sticky and clear
    wr(1, 16'h0080, w);
    rd(1, v);
    check("R7 write 1 keeps flag", (v >> 7) & 1, 1);
    wr(1, 16'h0000, w);
    rd(1, v);
    check("R7 write 0 clears flag", (v >> 7) & 1, 0);

    // R3 and R4: each divider, restart after arbitrary stop
    for (int s = 1; s < 4; s++) begin
      wr(2, 0, w);
      wr(3, 1, w);
      wr(1, s, w);
      rd(1, v);
      check("R3 select readback", v & 3, s);
      start_and_expect(s, 1, 0, 2, w);
      wait_until(w + period_of(s) * 4 + 2);
      wr(0, 0, v2);
      check("R3/R4 pulses per divider", exp_q.size(), 0);
    end

    // R8 counter load shortens first period
    wr(1, 0, w);
    wr(2, 5, w);
    wr(3, 7, w);
    rd(2, v);
    check("R8 counter readback", v, 5);
    start_and_expect(0, 7, 5, 2, w);
    wait_until(w + 12 + 32 + 2);
    wr(0, 0, v2);
    check("R8 loaded count match", exp_q.size(), 0);

    // R9 limit zero: pulse every tick
    wr(2, 0, w);
    wr(3, 0, w);
    start_and_expect(0, 0, 0, 4, w);
    wait_until(w + 17);
    wr(0, 0, v2);
    check("R9 every tick matches", exp_q.size(), 0);
    rd(2, v);
    check("R9 counter stays zero", v, 0);

    repeat (80) @(negedge clk);
    check("R2 no pulse while stopped", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule